// File: doc/BRIEF.md
# Nine-Bit Level-Sensitive Latch with Parity

This block stores a nine-bit data word in a level-sensitive latch and holds, beside it, a tenth bit that is the odd parity of the nine inputs. While the hold input is low, the latch is open: the data outputs and the parity output follow the inputs with no clock involved. When hold goes high, both the word and its parity freeze at the values they had at that moment. An asynchronous, active-high clear forces every output to zero and overrides the hold input.

The block can also act as a byte parity generator. The low eight inputs carry the byte and the top input chooses the parity type. The parity output is then the parity bit for that byte.

Top module: `parity_latch9`

## Requirements
- R1: While `rst_i` is 0 and `hold_i` is 0, `q_o` equals `d_i` and follows every change of `d_i`.
- R2: While `rst_i` is 0 and `hold_i` is 0, `par_o` is 1 exactly when an odd number of the nine bits of `d_i` are 1.
- R3: While `rst_i` is 0 and `hold_i` is 1, `q_o` and `par_o` keep the values they had when `hold_i` rose, whatever `d_i` does.
- R4: While `rst_i` is 1, `q_o` is 0 and `par_o` is 0, whatever the values of `hold_i` and `d_i`.
- R5: When `rst_i` falls while `hold_i` is 1, `q_o` and `par_o` stay 0 until `hold_i` next goes low.
- R6: In byte mode, `d_i[7:0]` carries the byte and `d_i[8]` is the type select. With select 0, `par_o` makes the nine-bit total of ones even. With select 1, it makes the total odd.
- R7: In every state, `par_o` equals the XOR of the nine bits of `q_o`, because the word and its parity are always stored together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| d_i | input | 9 | Data word; bit 8 doubles as the parity-type select in byte mode |
| hold_i | input | 1 | High holds the stored word; low makes the latch transparent |
| rst_i | input | 1 | Asynchronous active-high clear; overrides `hold_i` |
| q_o | output | 9 | Stored or passed-through data word |
| par_o | output | 1 | Stored or passed-through odd parity of the data inputs |

## Verification
The bench changes `d_i` many times while the latch is holding. A design that leaked data through would show the new word, and one that recomputed parity from the live inputs would move `par_o` away from the held word. It releases the clear while hold is high: a latch that reopened on reset release would show whatever is on `d_i` instead of zeros. It asserts the clear while the latch is open, to catch a clear that gives way to the enable. It runs byte mode with both select values and with bytes of even and of odd weight. A parity bit with the wrong sense, or one that left out bit 8, fails there.

// File: rtl/plat_pkg.sv
package plat_pkg;

  localparam int PARITY_MAX_W = 64;

  typedef enum logic [1:0] {
    MODE_CLEAR = 2'd0,
    MODE_PASS  = 2'd1,
    MODE_HOLD  = 2'd2
  } latch_mode_e;

  // Odd parity of a vector up to PARITY_MAX_W bits; callers zero-extend.
  function automatic logic odd_parity(input logic [PARITY_MAX_W-1:0] v);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < PARITY_MAX_W; i++) acc = acc ^ v[i];
    return acc;
  endfunction

endpackage

// File: rtl/plat_ctrl.sv
module plat_ctrl
  import plat_pkg::*;
(
  input  logic        hold_i,
  input  logic        rst_i,
  output latch_mode_e mode_o,
  output logic        open_o,
  output logic        clr_o
);

  always_comb begin
    if (rst_i)        mode_o = MODE_CLEAR;
    else if (!hold_i) mode_o = MODE_PASS;
    else              mode_o = MODE_HOLD;
  end

  assign clr_o  = (mode_o == MODE_CLEAR);
  assign open_o = (mode_o == MODE_PASS);

endmodule

// File: rtl/plat_parity.sv
module plat_parity
  import plat_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic [DATA_W-1:0] d_i,
  output logic              par_o
);

  localparam int PAD_W = PARITY_MAX_W - DATA_W;

  logic [PARITY_MAX_W-1:0] wide_w;

  generate
    if (PAD_W > 0) begin : g_pad
      assign wide_w = {{PAD_W{1'b0}}, d_i};
    end else begin : g_nopad
      assign wide_w = d_i[PARITY_MAX_W-1:0];
    end
  endgenerate

  assign par_o = odd_parity(wide_w);

endmodule

// File: rtl/plat_cell.sv
module plat_cell #(
  parameter int CELL_W = 1
) (
  input  logic [CELL_W-1:0] d_i,
  input  logic              open_i,
  input  logic              clr_i,
  output logic [CELL_W-1:0] q_o
);

  logic [CELL_W-1:0] store_q;

  always_latch begin
    if (clr_i)       store_q = '0;
    else if (open_i) store_q = d_i;
  end

  assign q_o = store_q;

endmodule

// File: rtl/parity_latch9.sv
module parity_latch9
  import plat_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic [DATA_W-1:0] d_i,
  input  logic              hold_i,
  input  logic              rst_i,
  output logic [DATA_W-1:0] q_o,
  output logic              par_o
);

  latch_mode_e mode_w;
  logic        open_w;
  logic        clr_w;
  logic        par_in_w;

  plat_ctrl u_ctrl (
    .hold_i (hold_i),
    .rst_i  (rst_i),
    .mode_o (mode_w),
    .open_o (open_w),
    .clr_o  (clr_w)
  );

  // Parity is formed from the inputs ahead of storage.
  plat_parity #(.DATA_W(DATA_W)) u_par (
    .d_i   (d_i),
    .par_o (par_in_w)
  );

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      plat_cell #(.CELL_W(1)) u_cell (
        .d_i    (d_i[b]),
        .open_i (open_w),
        .clr_i  (clr_w),
        .q_o    (q_o[b])
      );
    end
  endgenerate

  plat_cell #(.CELL_W(1)) u_par_cell (
    .d_i    (par_in_w),
    .open_i (open_w),
    .clr_i  (clr_w),
    .q_o    (par_o)
  );

endmodule

// File: rtl/parity_latch9_chk.sv
module parity_latch9_chk
  import plat_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic [DATA_W-1:0] d_i,
  input  logic              hold_i,
  input  logic              rst_i,
  input  logic [DATA_W-1:0] q_o,
  input  logic              par_o,
  input  logic              open_w,
  input  logic              clr_w
);

  always_comb begin
    if (open_w) begin
      assert_pass_data_R1: assert (q_o == d_i);
    end
  end

  always_comb begin
    if (!rst_i && !hold_i) begin
      assert_pass_parity_R2: assert (par_o == (^d_i));
    end
  end

  always_comb begin
    if (clr_w) begin
      assert_clear_R4: assert (q_o == '0 && par_o == 1'b0);
    end
  end

  always_comb begin
    assert_par_matches_word_R7: assert (par_o == (^q_o));
  end

  // Stored contents may only move while open or clearing (R3, R5).
  always @(q_o or par_o) begin
    assert_no_change_on_hold_R3: assert (rst_i || !hold_i);
  end

endmodule

bind parity_latch9 parity_latch9_chk #(.DATA_W(DATA_W)) u_chk (
  .d_i    (d_i),
  .hold_i (hold_i),
  .rst_i  (rst_i),
  .q_o    (q_o),
  .par_o  (par_o),
  .open_w (open_w),
  .clr_w  (clr_w)
);

// File: tb/test_parity_latch9.sv
`timescale 1ns/1ps
module test_parity_latch9;

  logic       clk = 1'b0;
  logic [8:0] d;
  logic       hold;
  logic       rst;
  logic [8:0] q;
  logic       par;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  parity_latch9 i_parity_latch9 (
    .d_i    (d),
    .hold_i (hold),
    .rst_i  (rst),
    .q_o    (q),
    .par_o  (par)
  );

  function automatic logic count_odd(input logic [8:0] v);
    int n = 0;
    for (int i = 0; i < 9; i++) if (v[i]) n++;
    return (n % 2) == 1;
  endfunction

  function automatic logic [8:0] next_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[20:12];
  endfunction

  task automatic check(input string req, input logic [8:0] exp_q, input logic exp_p);
    checks++;
    if (q !== exp_q || par !== exp_p) begin
      errors++;
      $display("FAIL %s: q=%h par=%b expected q=%h par=%b", req, q, par, exp_q, exp_p);
    end
  endtask

  task automatic apply(input logic [8:0] nd, input logic nh, input logic nr);
    d = nd; hold = nh; rst = nr;
    #1;
  endtask

  task automatic t_reset_state();
    apply(9'h1ff, 1'b0, 1'b1);
    check("R4 reset while open", 9'h000, 1'b0);
    apply(9'h0a5, 1'b1, 1'b1);
    check("R4 reset while holding", 9'h000, 1'b0);
  endtask

  task automatic t_transparent();
    logic [8:0] v;
    apply(9'h000, 1'b0, 1'b0);
    check("R1 R2 open zero", 9'h000, 1'b0);
    for (int k = 0; k < 20; k++) begin
      v = next_rand();
      apply(v, 1'b0, 1'b0);
      check("R1 R2 open random", v, count_odd(v));
    end
    apply(9'h1ff, 1'b0, 1'b0);
    check("R2 all ones", 9'h1ff, 1'b1);
    apply(9'h100, 1'b0, 1'b0);
    check("R2 single top bit", 9'h100, 1'b1);
  endtask

  task automatic t_hold();
    logic [8:0] kept;
    for (int r = 0; r < 4; r++) begin
      kept = next_rand();
      apply(kept, 1'b0, 1'b0);
      apply(kept, 1'b1, 1'b0);
      for (int k = 0; k < 6; k++) begin
        apply(next_rand(), 1'b1, 1'b0);
        check("R3 R7 held word", kept, count_odd(kept));
      end
      apply(~kept, 1'b1, 1'b0);
      check("R3 complement input", kept, count_odd(kept));
    end
  endtask

  task automatic t_reset_release_hold();
    apply(9'h0f3, 1'b1, 1'b1);
    apply(9'h0f3, 1'b1, 1'b0);
    check("R5 released while holding", 9'h000, 1'b0);
    apply(9'h1c1, 1'b1, 1'b0);
    check("R5 input moves, still zero", 9'h000, 1'b0);
    apply(9'h1c1, 1'b0, 1'b0);
    check("R5 reopen", 9'h1c1, count_odd(9'h1c1));
    apply(9'h037, 1'b0, 1'b1);
    check("R4 clear overrides open", 9'h000, 1'b0);
    apply(9'h037, 1'b0, 1'b0);
    check("R1 after clear", 9'h037, count_odd(9'h037));
  endtask

  task automatic t_byte_mode();
    logic [7:0] b;
    logic       pbit;
    for (int k = 0; k < 8; k++) begin
      b = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : next_rand() & 9'h0ff;
      for (int s = 0; s < 2; s++) begin
        apply({s[0], b}, 1'b0, 1'b0);
        pbit = par;
        checks++;
        if (((count_odd({1'b0, b}) ^ pbit) !== s[0])) begin
          errors++;
          $display("FAIL R6: byte=%h sel=%0d par=%b expected %b", b, s, pbit,
                   count_odd({1'b0, b}) ^ s[0]);
        end
      end
    end
  endtask

  initial begin
    t_reset_state();
    t_transparent();
    t_hold();
    t_reset_release_hold();
    t_byte_mode();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule